// File: doc/BRIEF.md
# Decoded Frame Buffer Manager

This block keeps track of a small pool of picture buffers that live in external memory and are shared by a video decoder, a display engine and a motion-compensation unit. A constant pointer table gives the base address of each buffer. Per-buffer flags record whether a buffer is being decoded, whether it sits in the reference list, and whether it waits for, or is on, the screen. A display queue keeps decoded pictures in decode order.

The decoder asks for a buffer when a picture starts. The block scans the pool one buffer per cycle for a free one. When the picture ends, the decoder asks the block to insert it: the picture enters the reference list at index 0 and joins the display queue. The display asks for a picture once per refresh. It gets the next queued picture once the current one has been shown the minimum number of times. Otherwise it gets the current picture again, which converts a slow decode rate to a faster refresh rate. Motion compensation turns a reference index into a base address with a one-cycle lookup.

Each request is a level held until its one-cycle acknowledge. The three request kinds are served one at a time, and the display always goes first.

Top module: `fbm_top`

## Requirements
- R1: After reset, dec_alloc_ack, dec_done_ack, disp_ack and mc_ref_hit are all low.
- R2: An allocation picks the lowest-numbered free buffer and returns its number on dec_alloc_buf and BASE_ADDR + number*FRAME_BYTES on dec_alloc_base, with a one-cycle dec_alloc_ack.
- R3: An allocation request while a picture is still being decoded returns the buffer of that picture and allocates nothing new.
- R4: An end-of-picture request puts the active buffer at reference index 0 and moves older entries up one index. The entry pushed past index NUM_REF-1 leaves the list. With no active picture the request is acknowledged and the list is unchanged.
- R5: mc_ref_base and mc_ref_hit reflect mc_ref_idx one cycle after it is applied. mc_ref_hit is 0 for an empty list slot.
- R6: A display request gets the oldest queued picture (disp_valid=1, disp_repeat=0) when nothing is on screen or the current picture has been shown at least rep_min times. Otherwise it gets the current picture again (disp_valid=1, disp_repeat=1).
- R7: A display request with no picture ever queued is acknowledged with disp_valid=0.
- R8: A buffer that is being decoded, in the reference list, queued for display or on screen is never handed out. While all buffers are in such a state, an allocation stays unacknowledged.
- R9: When display and decoder requests are pending together, the display is acknowledged first. At most one acknowledge is high in any cycle.
- R10: Once a buffer has left both the screen and the reference list, it can be allocated again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dec_alloc_req | input | 1 | Decoder asks for a buffer for a new picture |
| dec_alloc_ack | output | 1 | One-cycle grant of the allocation |
| dec_alloc_buf | output | IDX_W | Granted buffer number |
| dec_alloc_base | output | AW | Base address of granted buffer |
| dec_done_req | input | 1 | Decoder finished the active picture |
| dec_done_ack | output | 1 | One-cycle acknowledge of insertion |
| disp_req | input | 1 | Display asks for the next picture |
| disp_ack | output | 1 | One-cycle acknowledge of display request |
| disp_valid | output | 1 | A picture is returned |
| disp_repeat | output | 1 | Returned picture is the one already on screen |
| disp_buf | output | IDX_W | Buffer number to show |
| disp_base | output | AW | Base address of picture to show |
| rep_min | input | REP_W | Minimum showings per picture before advancing |
| mc_ref_idx | input | RIDX_W | Reference index to look up |
| mc_ref_base | output | AW | Base address for that index |
| mc_ref_hit | output | 1 | Index holds a picture |

## Verification
The bench fills the pool until every buffer is held for a different reason: one being on screen, others queued, others in the reference list. It then checks that an allocation waits rather than taking a buffer that is still in use. A design that only looked at the reference flag would hand out a queued picture and corrupt the display. It drives display and end-of-picture requests in the same cycle to catch a design that serves the decoder first. It steps the display through new-picture and repeat cases with a minimum showing count above one. A design that advanced too early, or released the wrong buffer, would show the wrong number or reuse a buffer too soon. The sliding reference list is checked by index after each insertion, including the entry that drops out.

// File: rtl/fbm_pkg.sv
package fbm_pkg;
  typedef enum logic [0:0] {ST_IDLE, ST_SCAN} fbm_state_e;
endpackage

// File: rtl/fbm_ptr_mem.sv
module fbm_ptr_mem #(
  parameter int          NUM_BUF     = 4,
  parameter int          AW          = 32,
  parameter logic [31:0] BASE_ADDR   = 32'h1000_0000,
  parameter logic [31:0] FRAME_BYTES = 32'h0030_0000,
  localparam int         IDX_W       = (NUM_BUF > 1) ? $clog2(NUM_BUF) : 1
) (
  input  logic [IDX_W-1:0] a_idx,
  input  logic [IDX_W-1:0] b_idx,
  input  logic [IDX_W-1:0] c_idx,
  output logic [AW-1:0]    a_base,
  output logic [AW-1:0]    b_base,
  output logic [AW-1:0]    c_base
);
  logic [AW-1:0] tbl [NUM_BUF];

  for (genvar g = 0; g < NUM_BUF; g++) begin : g_entry
    assign tbl[g] = AW'(BASE_ADDR + 32'(g) * FRAME_BYTES);
  end

  assign a_base = tbl[a_idx];
  assign b_base = tbl[b_idx];
  assign c_base = tbl[c_idx];
endmodule

// File: rtl/fbm_reflist.sv
module fbm_reflist #(
  parameter int  NUM_REF = 2,
  parameter int  IDX_W   = 2,
  localparam int RIDX_W  = (NUM_REF > 1) ? $clog2(NUM_REF) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ins,
  input  logic [IDX_W-1:0]  ins_buf,
  output logic              drop_v,
  output logic [IDX_W-1:0]  drop_buf,
  input  logic [RIDX_W-1:0] rd_idx,
  output logic              rd_hit,
  output logic [IDX_W-1:0]  rd_buf
);
  logic [IDX_W-1:0] slot_buf [NUM_REF];
  logic [NUM_REF-1:0] slot_v;

  always_ff @(posedge clk) begin
    if (rst) slot_v <= '0;
    else if (ins) slot_v <= {slot_v[NUM_REF-2:0], 1'b1};
  end

  always_ff @(posedge clk) begin
    if (ins) slot_buf[0] <= ins_buf;
  end

  for (genvar g = 1; g < NUM_REF; g++) begin : g_shift
    always_ff @(posedge clk) begin
      if (ins) slot_buf[g] <= slot_buf[g-1];
    end
  end

  assign drop_v   = ins && slot_v[NUM_REF-1];
  assign drop_buf = slot_buf[NUM_REF-1];

  always_comb begin
    rd_hit = 1'b0;
    rd_buf = '0;
    if (32'(rd_idx) < NUM_REF) begin
      rd_hit = slot_v[rd_idx];
      rd_buf = slot_buf[rd_idx];
    end
  end
endmodule

// File: rtl/fbm_dispq.sv
module fbm_dispq #(
  parameter int DEPTH = 4,
  parameter int IDX_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic [IDX_W-1:0] push_buf,
  input  logic             pop,
  output logic             empty,
  output logic [IDX_W-1:0] head
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  logic [IDX_W-1:0] mem [DEPTH];
  logic [PW-1:0]    wr_p, rd_p;
  logic [PW:0]      cnt;

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (32'(p) == DEPTH - 1) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push) mem[wr_p] <= push_buf;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_p <= '0;
      rd_p <= '0;
      cnt  <= '0;
    end else begin
      if (push) wr_p <= nxt(wr_p);
      if (pop)  rd_p <= nxt(rd_p);
      cnt <= cnt + (PW+1)'(push) - (PW+1)'(pop);
    end
  end

  assign empty = (cnt == '0);
  assign head  = mem[rd_p];
endmodule

// File: rtl/fbm_top.sv
module fbm_top #(
  parameter int          NUM_BUF     = 4,
  parameter int          NUM_REF     = 2,
  parameter int          AW          = 32,
  parameter int          REP_W       = 3,
  parameter logic [31:0] BASE_ADDR   = 32'h1000_0000,
  parameter logic [31:0] FRAME_BYTES = 32'h0030_0000,
  localparam int         IDX_W       = (NUM_BUF > 1) ? $clog2(NUM_BUF) : 1,
  localparam int         RIDX_W      = (NUM_REF > 1) ? $clog2(NUM_REF) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              dec_alloc_req,
  output logic              dec_alloc_ack,
  output logic [IDX_W-1:0]  dec_alloc_buf,
  output logic [AW-1:0]     dec_alloc_base,
  input  logic              dec_done_req,
  output logic              dec_done_ack,
  input  logic              disp_req,
  output logic              disp_ack,
  output logic              disp_valid,
  output logic              disp_repeat,
  output logic [IDX_W-1:0]  disp_buf,
  output logic [AW-1:0]     disp_base,
  input  logic [REP_W-1:0]  rep_min,
  input  logic [RIDX_W-1:0] mc_ref_idx,
  output logic [AW-1:0]     mc_ref_base,
  output logic              mc_ref_hit
);
  import fbm_pkg::*;

  fbm_state_e        state;
  logic [IDX_W-1:0]  scan_ptr;
  logic [NUM_BUF-1:0] dec_f, ref_f, dsp_f;
  logic              act_v, cur_v;
  logic [IDX_W-1:0]  act_buf, cur_buf;
  logic [REP_W-1:0]  shows;

  logic              ack_any, idle_go, take_new, do_ins, scan_free;
  logic              q_empty, drop_v, rl_hit;
  logic [IDX_W-1:0]  q_head, drop_buf, rl_buf;
  logic [AW-1:0]     scan_base, head_base, lk_base;

  assign ack_any   = dec_alloc_ack | dec_done_ack | disp_ack;
  assign idle_go   = (state == ST_IDLE) && !ack_any;
  assign take_new  = idle_go && disp_req && !q_empty && (!cur_v || shows >= rep_min);
  assign do_ins    = idle_go && !disp_req && dec_done_req && act_v;
  assign scan_free = !(dec_f[scan_ptr] | ref_f[scan_ptr] | dsp_f[scan_ptr]);

  fbm_ptr_mem #(.NUM_BUF(NUM_BUF), .AW(AW), .BASE_ADDR(BASE_ADDR),
                .FRAME_BYTES(FRAME_BYTES)) ptr_i (
    .a_idx(scan_ptr), .b_idx(q_head), .c_idx(rl_buf),
    .a_base(scan_base), .b_base(head_base), .c_base(lk_base)
  );

  fbm_reflist #(.NUM_REF(NUM_REF), .IDX_W(IDX_W)) rl_i (
    .clk(clk), .rst(rst), .ins(do_ins), .ins_buf(act_buf),
    .drop_v(drop_v), .drop_buf(drop_buf),
    .rd_idx(mc_ref_idx), .rd_hit(rl_hit), .rd_buf(rl_buf)
  );

  fbm_dispq #(.DEPTH(NUM_BUF), .IDX_W(IDX_W)) q_i (
    .clk(clk), .rst(rst), .push(do_ins), .push_buf(act_buf),
    .pop(take_new), .empty(q_empty), .head(q_head)
  );

  // motion-compensation lookup, one registered stage
  always_ff @(posedge clk) begin
    if (rst) begin
      mc_ref_hit  <= 1'b0;
      mc_ref_base <= '0;
    end else begin
      mc_ref_hit  <= rl_hit;
      mc_ref_base <= rl_hit ? lk_base : '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state          <= ST_IDLE;
      scan_ptr       <= '0;
      dec_f          <= '0;
      ref_f          <= '0;
      dsp_f          <= '0;
      act_v          <= 1'b0;
      act_buf        <= '0;
      cur_v          <= 1'b0;
      cur_buf        <= '0;
      shows          <= '0;
      dec_alloc_ack  <= 1'b0;
      dec_alloc_buf  <= '0;
      dec_alloc_base <= '0;
      dec_done_ack   <= 1'b0;
      disp_ack       <= 1'b0;
      disp_valid     <= 1'b0;
      disp_repeat    <= 1'b0;
      disp_buf       <= '0;
      disp_base      <= '0;
    end else begin
      dec_alloc_ack <= 1'b0;
      dec_done_ack  <= 1'b0;
      disp_ack      <= 1'b0;
      case (state)
        ST_IDLE: if (!ack_any) begin
          if (disp_req) begin
            disp_ack <= 1'b1;
            if (take_new) begin
              if (cur_v) dsp_f[cur_buf] <= 1'b0;
              cur_v       <= 1'b1;
              cur_buf     <= q_head;
              shows       <= REP_W'(1);
              disp_valid  <= 1'b1;
              disp_repeat <= 1'b0;
              disp_buf    <= q_head;
              disp_base   <= head_base;
            end else if (cur_v) begin
              if (shows != '1) shows <= shows + 1'b1;
              disp_valid  <= 1'b1;
              disp_repeat <= 1'b1;
            end else begin
              disp_valid  <= 1'b0;
              disp_repeat <= 1'b0;
            end
          end else if (dec_done_req) begin
            dec_done_ack <= 1'b1;
            if (act_v) begin
              dec_f[act_buf] <= 1'b0;
              ref_f[act_buf] <= 1'b1;
              dsp_f[act_buf] <= 1'b1;
              if (drop_v) ref_f[drop_buf] <= 1'b0;
              act_v <= 1'b0;
            end
          end else if (dec_alloc_req) begin
            if (act_v) begin
              dec_alloc_ack <= 1'b1;
            end else begin
              state    <= ST_SCAN;
              scan_ptr <= '0;
            end
          end
        end
        ST_SCAN: begin
          if (scan_free) begin
            dec_f[scan_ptr] <= 1'b1;
            act_v           <= 1'b1;
            act_buf         <= scan_ptr;
            dec_alloc_ack   <= 1'b1;
            dec_alloc_buf   <= scan_ptr;
            dec_alloc_base  <= scan_base;
            state           <= ST_IDLE;
          end else if (32'(scan_ptr) == NUM_BUF - 1) begin
            state <= ST_IDLE;
          end else begin
            scan_ptr <= scan_ptr + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/fbm_chk.sv
module fbm_chk #(
  parameter int          NUM_BUF     = 4,
  parameter int          AW          = 32,
  parameter logic [31:0] BASE_ADDR   = 32'h1000_0000,
  parameter logic [31:0] FRAME_BYTES = 32'h0030_0000,
  localparam int         IDX_W       = (NUM_BUF > 1) ? $clog2(NUM_BUF) : 1
) (
  input logic               clk,
  input logic               rst,
  input logic               dec_alloc_ack,
  input logic [IDX_W-1:0]   dec_alloc_buf,
  input logic [AW-1:0]      dec_alloc_base,
  input logic               dec_done_ack,
  input logic               disp_ack,
  input logic               disp_valid,
  input logic               disp_repeat,
  input logic [IDX_W-1:0]   disp_buf,
  input logic [NUM_BUF-1:0] ref_f,
  input logic [NUM_BUF-1:0] dsp_f
);
  logic             last_v;
  logic [IDX_W-1:0] last_buf;

  always_ff @(posedge clk) begin
    if (rst) begin
      last_v   <= 1'b0;
      last_buf <= '0;
    end else if (disp_ack && disp_valid) begin
      last_v   <= 1'b1;
      last_buf <= disp_buf;
    end
  end

  // R9
  one_ack_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({dec_alloc_ack, dec_done_ack, disp_ack}));

  // R2
  alloc_base_chk: assert property (@(posedge clk) disable iff (rst)
    dec_alloc_ack |-> dec_alloc_base == AW'(BASE_ADDR + 32'(dec_alloc_buf) * FRAME_BYTES));

  // R2
  alloc_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    dec_alloc_ack |=> !dec_alloc_ack);

  // R8
  no_reuse_chk: assert property (@(posedge clk) disable iff (rst)
    dec_alloc_ack |-> !ref_f[dec_alloc_buf] && !dsp_f[dec_alloc_buf]);

  // R6
  repeat_same_chk: assert property (@(posedge clk) disable iff (rst)
    disp_ack && disp_repeat |-> disp_valid && last_v && disp_buf == last_buf);
endmodule

bind fbm_top fbm_chk #(
  .NUM_BUF(NUM_BUF), .AW(AW), .BASE_ADDR(BASE_ADDR), .FRAME_BYTES(FRAME_BYTES)
) chk_i (
  .clk(clk), .rst(rst),
  .dec_alloc_ack(dec_alloc_ack), .dec_alloc_buf(dec_alloc_buf),
  .dec_alloc_base(dec_alloc_base), .dec_done_ack(dec_done_ack),
  .disp_ack(disp_ack), .disp_valid(disp_valid), .disp_repeat(disp_repeat),
  .disp_buf(disp_buf), .ref_f(ref_f), .dsp_f(dsp_f)
);

// File: tb/fbm_top_tb_top.sv
module fbm_top_tb_top;
  localparam int          NB   = 4;
  localparam int          NR   = 2;
  localparam logic [31:0] BASE = 32'h1000_0000;
  localparam logic [31:0] FB   = 32'h0030_0000;

  logic clk = 1'b0, rst = 1'b1;
  logic dec_alloc_req = 0, dec_done_req = 0, disp_req = 0;
  logic dec_alloc_ack, dec_done_ack, disp_ack, disp_valid, disp_repeat, mc_ref_hit;
  logic [1:0] dec_alloc_buf, disp_buf;
  logic [31:0] dec_alloc_base, disp_base, mc_ref_base;
  logic [2:0] rep_min = 3'd2;
  logic [0:0] mc_ref_idx = '0;
  int n_run = 0, n_fail = 0;

  always #2 clk = ~clk;

  fbm_top #(.NUM_BUF(NB), .NUM_REF(NR), .BASE_ADDR(BASE), .FRAME_BYTES(FB)) dut_i (
    .clk(clk), .rst(rst),
    .dec_alloc_req(dec_alloc_req), .dec_alloc_ack(dec_alloc_ack),
    .dec_alloc_buf(dec_alloc_buf), .dec_alloc_base(dec_alloc_base),
    .dec_done_req(dec_done_req), .dec_done_ack(dec_done_ack),
    .disp_req(disp_req), .disp_ack(disp_ack), .disp_valid(disp_valid),
    .disp_repeat(disp_repeat), .disp_buf(disp_buf), .disp_base(disp_base),
    .rep_min(rep_min), .mc_ref_idx(mc_ref_idx),
    .mc_ref_base(mc_ref_base), .mc_ref_hit(mc_ref_hit)
  );

  function automatic logic [31:0] base_of(input int b);
    return BASE + 32'(b) * FB;
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_sig(input string req, ref logic s, output bit got);
    got = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (s) begin got = 1; break; end
    end
    if (!got) check(req, 64'd0, 64'd1);
  endtask

  task automatic do_alloc(input string req, input int exp_buf);
    bit got;
    dec_alloc_req = 1;
    wait_sig(req, dec_alloc_ack, got);
    dec_alloc_req = 0;
    if (got) begin
      check(req, 64'(dec_alloc_buf), 64'(exp_buf));
      check(req, 64'(dec_alloc_base), 64'(base_of(exp_buf)));
    end
  endtask

  task automatic do_done(input string req);
    bit got;
    dec_done_req = 1;
    wait_sig(req, dec_done_ack, got);
    dec_done_req = 0;
  endtask

  task automatic do_disp(input string req, input bit ev, input bit er, input int eb);
    bit got;
    disp_req = 1;
    wait_sig(req, disp_ack, got);
    disp_req = 0;
    if (got) begin
      check(req, 64'(disp_valid), 64'(ev));
      if (ev) begin
        check(req, 64'(disp_repeat), 64'(er));
        check(req, 64'(disp_buf), 64'(eb));
        check(req, 64'(disp_base), 64'(base_of(eb)));
      end
    end
  endtask

  task automatic lookup(input string req, input int idx, input bit eh, input int eb);
    mc_ref_idx = 1'(idx);
    @(negedge clk);
    check(req, 64'(mc_ref_hit), 64'(eh));
    if (eh) check(req, 64'(mc_ref_base), 64'(base_of(eb)));
  endtask

  task automatic t_reset();
    // R1
    check("R1", {dec_alloc_ack, dec_done_ack, disp_ack, mc_ref_hit}, 64'd0);
  endtask

  task automatic t_empty();
    do_disp("R7", 0, 0, 0);
    do_done("R4");
    lookup("R4", 0, 0, 0);
    lookup("R5", 1, 0, 0);
  endtask

  task automatic t_fill();
    do_alloc("R2", 0);
    do_alloc("R3", 0);
    do_done("R4");
    lookup("R5", 0, 1, 0);
    lookup("R5", 1, 0, 0);
    do_alloc("R2", 1);
    do_done("R4");
    lookup("R4", 0, 1, 1);
    lookup("R4", 1, 1, 0);
  endtask

  task automatic t_display();
    do_disp("R6", 1, 0, 0);
    do_disp("R6", 1, 1, 0);
    do_disp("R6", 1, 0, 1);
    do_disp("R6", 1, 1, 1);
  endtask

  task automatic t_reuse();
    do_alloc("R2", 2);
    do_done("R4");
    lookup("R4", 0, 1, 2);
    lookup("R4", 1, 1, 1);
    do_alloc("R10", 0);
    do_done("R4");
    do_alloc("R8", 3);
    do_done("R4");
    lookup("R4", 0, 1, 3);
    lookup("R4", 1, 1, 0);
  endtask

  task automatic t_full();
    bit seen = 0;
    bit got;
    dec_alloc_req = 1;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (dec_alloc_ack) seen = 1;
    end
    check("R8", 64'(seen), 64'd0);
    do_disp("R6", 1, 0, 2);
    wait_sig("R10", dec_alloc_ack, got);
    dec_alloc_req = 0;
    if (got) check("R10", 64'(dec_alloc_buf), 64'd1);
  endtask

  task automatic t_priority();
    bit got;
    disp_req = 1;
    dec_done_req = 1;
    got = 0;
    for (int i = 0; i < 40 && !got; i++) begin
      @(negedge clk);
      if (disp_ack || dec_done_ack) got = 1;
    end
    check("R9", {disp_ack, dec_done_ack}, 64'b10);
    disp_req = 0;
    check("R6", {disp_repeat, 2'(disp_buf)}, {1'b1, 2'd2});
    wait_sig("R9", dec_done_ack, got);
    dec_done_req = 0;
    lookup("R4", 0, 1, 1);
    lookup("R4", 1, 1, 3);
    do_disp("R6", 1, 0, 0);
  endtask

  initial begin
    for (int i = 0; i < 100000; i++) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_empty();
    t_fill();
    t_display();
    t_reuse();
    t_full();
    t_priority();
    repeat (4) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule